// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block is the feedback divider of a frequency-synthesis loop. It divides an incoming high-rate clock by a programmable ratio of 8·M + A. A dual-modulus prescaler counts cycles of the input clock in groups of eight or nine. A 12-bit main counter counts completed prescaler groups. A 3-bit swallow counter keeps the prescaler in its divide-by-nine setting for the first A groups of every division cycle. Each completed division cycle produces a single one-clock pulse, which goes to the phase comparator of the loop.

The divisor values M and A are taken in only when a division cycle completes, and also while reset is held. The phase comparator therefore never sees a cycle of mixed length. The loop controller must keep A no larger than M.

For bring-up, a test input replaces the normal data on a general-purpose port pin with a toggle that flips on every divided pulse. The pin then carries the divided rate halved, as a square wave. When the test input is low, the pin carries ordinary port data and the toggle keeps its value.

Top module: `pulse_swallow_divider`

## Requirements
- R1: While `rst_n` is low, `div_pulse` is 0 and the half-rate toggle is cleared, so `port_out` reads 0 when `test_en` is 1.
- R2: For M in 1..4095 and A in 0..7 with A ≤ M, successive `div_pulse` pulses are exactly 8·M + A clock cycles apart.
- R3: `div_pulse` is high for exactly one clock per completed division cycle and is otherwise low.
- R4: After reset is released, the first `div_pulse` is high in the (8·M + A)-th clock cycle. The first cycle with `rst_n` high counts as cycle 1, and M and A are the values present during reset.
- R5: `m_in` and `a_in` are sampled only at the clock edge that completes a division cycle, and on edges while reset is held. A change at any other time does not alter the length of the running cycle.
- R6: An M value of 0 is treated as 1, giving a ratio of 8 when A is 0.
- R7: While `test_en` is 1, `port_out` equals the half-rate toggle. The toggle inverts at every completed division cycle, so `port_out` changes level in the same cycle that `div_pulse` goes high.
- R8: While `test_en` is 0, `port_out` equals `port_data` and the toggle holds its value. When `test_en` returns to 1, `port_out` shows the level it had when test mode was left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-rate clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| m_in | input | 12 | Main count M (number of prescaler groups) |
| a_in | input | 3 | Swallow count A (groups taken at divide-by-nine) |
| test_en | input | 1 | 1: route half-rate divided signal to the port pin |
| port_data | input | 1 | Ordinary data for the port pin |
| div_pulse | output | 1 | One-clock pulse per completed division cycle |
| port_out | output | 1 | Port pin value: `port_data` or the half-rate toggle |

## Verification
The bench changes M and A in the middle of a cycle and expects the running cycle to finish at its old length. A divider that reloaded at once would emit a pulse of the wrong spacing. The edge ratios are covered: A = M = 1 (9), A = M = 7 (63), M = 0 (8) and the largest ratio, 32767. A swallow counter that kept the divide-by-nine setting for too many or too few groups, or a main counter that wrapped at zero, would be off by one or more cycles, or by a whole 4096-group wrap. The bench also leaves test mode over several pulses and then re-enters it, expecting the toggle level to be unchanged. This catches a toggle that kept running or was cleared while the pin carried normal data.

// File: rtl/psd_pkg.sv
// Package: shared types for the pulse-swallow divider.
// Assumes nothing beyond IEEE 1800-2017 packages.
package psd_pkg;
    // Prescaler modulus selection: base ratio or base ratio plus one.
    typedef enum logic {
        MOD_BASE = 1'b0,
        MOD_PLUS = 1'b1
    } mod_sel_e;
endpackage

// File: rtl/psd_prescaler.sv
// Dual-modulus prescaler: counts BASE or BASE+1 input clocks per group
// and flags the last clock of each group.
// Assumes the modulus select is stable within a group (it changes only
// at group boundaries) and BASE >= 2.
module psd_prescaler #(
    parameter int BASE = 8,
    localparam int CW  = $clog2(BASE + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  psd_pkg::mod_sel_e      mod_sel,
    output logic                   grp_end,
    output logic [CW-1:0]          cnt
);
    import psd_pkg::*;

    localparam logic [CW-1:0] LAST_BASE = CW'(BASE - 1);
    localparam logic [CW-1:0] LAST_PLUS = CW'(BASE);

    logic [CW-1:0] last_idx;

    // Pick the final index of the current group from the modulus.
    always_comb begin
        last_idx = (mod_sel == MOD_PLUS) ? LAST_PLUS : LAST_BASE;
        grp_end  = (cnt == last_idx);
    end

    // Group counter: wraps to zero after the last clock of a group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (grp_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/psd_swallow_ctrl.sv
// Main and swallow counters: track the groups remaining in a division
// cycle, request the plus-one modulus while swallow groups remain, and
// flag the completing clock. New M/A values load only at completion
// (or during reset). Assumes A <= M; M = 0 behaves as M = 1.
module psd_swallow_ctrl #(
    parameter int M_W = 12,
    parameter int A_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [M_W-1:0]        m_in,
    input  logic [A_W-1:0]        a_in,
    input  logic                  grp_end,
    output psd_pkg::mod_sel_e     mod_sel,
    output logic                  cyc_done,
    output logic [M_W-1:0]        m_rem,
    output logic [A_W-1:0]        a_rem
);
    import psd_pkg::*;

    localparam logic [M_W-1:0] M_ONE = M_W'(1);

    logic last_grp;
    logic swallow_on;

    // Decode the final group and the swallow phase of the cycle.
    always_comb begin
        last_grp   = (m_rem <= M_ONE);
        swallow_on = (a_rem != '0);
        mod_sel    = swallow_on ? MOD_PLUS : MOD_BASE;
        cyc_done   = grp_end && last_grp;
    end

    // Main group counter: reload at cycle end, count down per group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_rem <= m_in;
        end else if (cyc_done) begin
            m_rem <= m_in;
        end else if (grp_end) begin
            m_rem <= m_rem - 1'b1;
        end
    end

    // Swallow counter: reload at cycle end, count down while nonzero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rem <= a_in;
        end else if (cyc_done) begin
            a_rem <= a_in;
        end else if (grp_end && swallow_on) begin
            a_rem <= a_rem - 1'b1;
        end
    end
endmodule

// File: rtl/psd_out_stage.sv
// Output stage: registers the cycle-complete strobe into the divided
// pulse, keeps a half-rate toggle while test mode is on, and muxes the
// port pin between ordinary data and the toggle.
// Assumes cyc_done is a single-clock strobe.
module psd_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_done,
    input  logic test_en,
    input  logic port_data,
    output logic div_pulse,
    output logic half_tog,
    output logic port_out
);
    // Divided pulse register: one clock wide per completed cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_pulse <= 1'b0;
        end else begin
            div_pulse <= cyc_done;
        end
    end

    // Half-rate toggle: flips per completed cycle only in test mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_tog <= 1'b0;
        end else if (test_en && cyc_done) begin
            half_tog <= ~half_tog;
        end
    end

    // Port pin select between normal data and the test toggle.
    always_comb begin
        port_out = test_en ? half_tog : port_data;
    end
endmodule

// File: rtl/pulse_swallow_divider.sv
// Top: programmable feedback divider with ratio BASE*M + A built from a
// dual-modulus prescaler, a main group counter and a swallow counter,
// plus a test path that puts the halved divided rate on a port pin.
// Assumes A <= M, synchronous active-low reset, single clock domain.
module pulse_swallow_divider #(
    parameter int M_W  = 12,
    parameter int A_W  = 3,
    parameter int BASE = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [M_W-1:0] m_in,
    input  logic [A_W-1:0] a_in,
    input  logic           test_en,
    input  logic           port_data,
    output logic           div_pulse,
    output logic           port_out
);
    import psd_pkg::*;

    localparam int PCW = $clog2(BASE + 1);

    mod_sel_e         mod_sel;
    logic             grp_end;
    logic [PCW-1:0]   pre_cnt;
    logic             cyc_done;
    logic [M_W-1:0]   m_rem;
    logic [A_W-1:0]   a_rem;
    logic             half_tog;

    psd_prescaler #(.BASE(BASE)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .mod_sel (mod_sel),
        .grp_end (grp_end),
        .cnt     (pre_cnt)
    );

    psd_swallow_ctrl #(.M_W(M_W), .A_W(A_W)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .m_in     (m_in),
        .a_in     (a_in),
        .grp_end  (grp_end),
        .mod_sel  (mod_sel),
        .cyc_done (cyc_done),
        .m_rem    (m_rem),
        .a_rem    (a_rem)
    );

    psd_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_done  (cyc_done),
        .test_en   (test_en),
        .port_data (port_data),
        .div_pulse (div_pulse),
        .half_tog  (half_tog),
        .port_out  (port_out)
    );
endmodule

// File: rtl/psd_checker.sv
// Checker: temporal properties of the pulse-swallow divider, bound to
// the top. Uses a saturating gap counter instead of deep $past windows.
module psd_checker #(
    parameter int M_W  = 12,
    parameter int A_W  = 3,
    parameter int BASE = 8,
    localparam int PCW = $clog2(BASE + 1),
    localparam int GW  = M_W + PCW + 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic [M_W-1:0] m_in,
    input logic           test_en,
    input logic           div_pulse,
    input logic           grp_end,
    input logic           cyc_done,
    input logic [PCW-1:0] pre_cnt,
    input logic [M_W-1:0] m_rem,
    input logic [A_W-1:0] a_rem,
    input logic           half_tog
);
    logic [GW-1:0] gap;

    // Count clocks since the last divided pulse (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n || div_pulse) begin
            gap <= '0;
        end else if (gap != '1) begin
            gap <= gap + 1'b1;
        end
    end

    AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse); // R3

    AST_PULSE_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> (gap >= GW'(BASE - 1))); // R2

    AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= PCW'(BASE)); // R2

    AST_RELOAD_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> (m_rem == $past(m_in))); // R5

    AST_HOLD_MID_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (!grp_end && !cyc_done) |=> ($stable(m_rem) && $stable(a_rem))); // R5

    AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && test_en) |=> (half_tog != $past(half_tog))); // R7

    AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> $stable(half_tog)); // R8
endmodule

bind pulse_swallow_divider psd_checker #(.M_W(M_W), .A_W(A_W), .BASE(BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .m_in      (m_in),
    .test_en   (test_en),
    .div_pulse (div_pulse),
    .grp_end   (grp_end),
    .cyc_done  (cyc_done),
    .pre_cnt   (pre_cnt),
    .m_rem     (m_rem),
    .a_rem     (a_rem),
    .half_tog  (half_tog)
);

// File: tb/pulse_swallow_divider_test.sv
// Bench: behavioural countdown model compared every clock, plus directed
// gap checks for the ratio corners, mid-cycle reload and test mode.
module pulse_swallow_divider_test;
    localparam int CLK_P = 10;
    localparam int WDOG  = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] m_in = 12'd5;
    logic [2:0]  a_in = 3'd3;
    logic        test_en = 1'b0;
    logic        port_data = 1'b0;
    logic        div_pulse;
    logic        port_out;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int since   = 0;
    int last_gap = 0;
    int pulse_cnt = 0;

    int  period = 0;
    int  cnt    = 0;
    bit  exp_pulse = 1'b0;
    bit  exp_tog   = 1'b0;

    pulse_swallow_divider uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .m_in      (m_in),
        .a_in      (a_in),
        .test_en   (test_en),
        .port_data (port_data),
        .div_pulse (div_pulse),
        .port_out  (port_out)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic int ratio(input int m, input int a);
        return 8 * ((m == 0) ? 1 : m) + a;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Reference model update at each edge, then compare a quarter period later.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            period    = ratio(int'(m_in), int'(a_in));
            cnt       = 0;
            exp_pulse = 1'b0;
            exp_tog   = 1'b0;
        end else begin
            cnt++;
            exp_pulse = (cnt == period);
            if (exp_pulse) begin
                cnt = 0;
                if (test_en) exp_tog = ~exp_tog;
                period = ratio(int'(m_in), int'(a_in));
            end
        end
        #(CLK_P/4);
        check(div_pulse === exp_pulse, "R3 pulse timing", int'(div_pulse), int'(exp_pulse));
        if (test_en)
            check(port_out === exp_tog, "R7 port toggle", int'(port_out), int'(exp_tog));
        else
            check(port_out === port_data, "R8 port data", int'(port_out), int'(port_data));
        if (!rst_n) begin
            since = 0;
        end else begin
            since++;
            if (div_pulse === 1'b1) begin
                last_gap = since;
                since = 0;
                pulse_cnt++;
            end
        end
        if (cyc > WDOG) begin
            check(1'b0, "watchdog", cyc, WDOG);
            finish_run();
        end
    end

    task automatic wait_pulse();
        int c0 = pulse_cnt;
        wait (pulse_cnt != c0);
    endtask

    task automatic set_ma(input int m, input int a);
        @(negedge clk);
        m_in = 12'(m);
        a_in = 3'(a);
    endtask

    // Load a ratio, let the running cycle finish, then measure one cycle.
    task automatic measure(input int m, input int a, input string req);
        set_ma(m, a);
        wait_pulse();
        wait_pulse();
        check(last_gap == ratio(m, a), req, last_gap, ratio(m, a));
    endtask

    bit held;

    initial begin
        repeat (3) @(negedge clk);
        check(div_pulse === 1'b0, "R1 pulse in reset", int'(div_pulse), 0);
        test_en = 1'b1;
        #1;
        check(port_out === 1'b0, "R1 toggle cleared", int'(port_out), 0);
        test_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        wait_pulse();
        check(last_gap == 43, "R4 first pulse", last_gap, 43);

        measure(1, 0, "R2 ratio 8");
        measure(1, 1, "R2 ratio 9");
        measure(7, 7, "R2 ratio 63");
        measure(0, 0, "R6 zero M");

        // R5: change values mid-cycle; running cycle keeps old length.
        set_ma(10, 2);
        wait_pulse();
        wait_pulse();
        repeat (20) @(negedge clk);
        m_in = 12'd3;
        a_in = 3'd1;
        wait_pulse();
        check(last_gap == 82, "R5 mid-cycle change", last_gap, 82);
        wait_pulse();
        check(last_gap == 25, "R5 new ratio", last_gap, 25);

        // R7: test mode toggles once per divided pulse.
        @(negedge clk);
        port_data = 1'b1;
        test_en   = 1'b1;
        wait_pulse();
        held = port_out;
        wait_pulse();
        check(port_out === ~held, "R7 half rate", int'(port_out), int'(~held));
        held = port_out;

        // R8: leave test mode across pulses; toggle must hold.
        @(negedge clk);
        test_en = 1'b0;
        port_data = 1'b0;
        #1;
        check(port_out === 1'b0, "R8 pass 0", int'(port_out), 0);
        port_data = 1'b1;
        #1;
        check(port_out === 1'b1, "R8 pass 1", int'(port_out), 1);
        wait_pulse();
        wait_pulse();
        wait_pulse();
        @(negedge clk);
        test_en = 1'b1;
        #1;
        check(port_out === held, "R8 toggle held", int'(port_out), int'(held));

        measure(4095, 7, "R2 ratio max");
        finish_run();
    end
endmodule